// File: doc/BRIEF.md
# Bidirectional GPIO Port with PWM and Slave-Port Muxing

This block controls an eight-pin bidirectional I/O port that sits in front of external tri-state pads. Software uses a small synchronous register bus to program a direction register, where a 1 marks a pin as an input. It also programs an output latch and reads back either the latch or the pad levels, which pass through a synchronizer. Each pin produces a drive value and an active-high output enable for its pad.

Two other functions can take pins away from plain GPIO control. A PWM generator running in half-bridge or full-bridge mode takes over the upper three pins as channels B, C and D. When a slave-port request is set, the whole port becomes an eight-bit data port for an external host, and the input threshold select moves to TTL levels. The takeover always has highest priority. Any PWM bridge mode blocks the slave port, whatever the request says.

A four-state mode machine sets the priority. The states are `ST_GPIO`, `ST_SLAVE`, `ST_HALF` and `ST_FULL`. On every clock edge the machine goes to `ST_FULL` when the PWM mode is 10 or 11, or to `ST_HALF` when the PWM mode is 01. With PWM mode 00 it goes to `ST_SLAVE` when the slave request is high, and to `ST_GPIO` otherwise. Each transition therefore takes effect one cycle after its inputs change.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 0xFF, the output latch reads 0x00, every `pad_oe` bit is 0, and `slave_active` and `ttl_sel` are 0.
- R2: In GPIO control, a pin whose direction bit is 1 has `pad_oe` 0. A pin whose direction bit is 0 has `pad_oe` 1 and drives its latch bit. Writing 0xCF to the direction register (address 2) gives `pad_oe` = 0x30.
- R3: A read at address 1 returns the stored latch value, not the pad level.
- R4: A write at address 0 or at address 1 loads the output latch. The new value is readable after the next rising clock edge, and writing 0 at either address clears it.
- R5: A read at address 0 returns `pad_in` through two flip-flops. A pad change is invisible after one rising edge and visible after the second.
- R6: PWM mode 01 takes bit 5 for channel B. PWM modes 10 and 11 take bits 5, 6 and 7 for channels B, C and D. A taken pin has `pad_oe` 1 and drives its channel level, whatever its direction bit or the slave mode.
- R7: With PWM mode 00 and `slave_req` high, after one edge `slave_active` and `ttl_sel` are 1. Every pin then has `pad_oe` equal to `slave_drive` and drives `slave_dout`.
- R8: Any non-zero PWM mode holds `slave_active` and `ttl_sel` at 0 from the next edge on, even with `slave_req` high. Pins that are not taken then follow the direction register.
- R9: Address 2 reads back the direction register. Address 3 reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 pins, 1 latch, 2 direction, 3 unused |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables, active high |
| pwm_mode | input | 2 | 00 off or single, 01 half-bridge, 10/11 full-bridge |
| pwm_b | input | 1 | PWM channel B level |
| pwm_c | input | 1 | PWM channel C level |
| pwm_d | input | 1 | PWM channel D level |
| slave_req | input | 1 | Slave data-port mode request |
| slave_drive | input | 1 | Slave port drives the pads (host read cycle) |
| slave_dout | input | 8 | Data the slave port presents to the host |
| slave_active | output | 1 | Slave data-port mode in effect |
| ttl_sel | output | 1 | Input threshold select: 1 TTL, 0 Schmitt |

## Verification
The hardest case to reach is a slave request that arrives while a bridge mode owns the upper pins. In that case the three taken pins, the slave drive and the direction register all want to control the same pads. The random loop draws the PWM mode, the slave request, the drive strobe and the direction value independently, so it lands in this conflict many times. Directed steps then switch the PWM mode off and on under a constant slave request. The bench keeps an external-driver model of the pad loop, so readback at address 0 depends on which source won each pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W  = 8;
    localparam int PWM_LSB = 5;

    localparam logic [1:0] ADDR_PIN = 2'd0;
    localparam logic [1:0] ADDR_LAT = 2'd1;
    localparam logic [1:0] ADDR_DIR = 2'd2;

    localparam logic [1:0] PWM_OFF  = 2'b00;
    localparam logic [1:0] PWM_HALF = 2'b01;

    typedef enum logic [1:0] {
        ST_GPIO  = 2'd0,
        ST_SLAVE = 2'd1,
        ST_HALF  = 2'd2,
        ST_FULL  = 2'd3
    } port_state_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   addr,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] rdata
);
    logic hit_latch;
    logic hit_dir;

    assign hit_latch = we && (addr == ADDR_PIN || addr == ADDR_LAT);
    assign hit_dir   = we && (addr == ADDR_DIR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else begin
            if (hit_latch) latch_q <= wdata;
            if (hit_dir)   dir_q   <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_PIN: rdata = pin_sync;
            ADDR_LAT: rdata = latch_q;
            ADDR_DIR: rdata = dir_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_mode_fsm.sv
module gpio_mode_fsm
    import gpio_port_pkg::*;
#(
    parameter int W   = 8,
    parameter int LSB = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  pwm_mode,
    input  logic        slave_req,
    output port_state_t state,
    output logic [W-1:0] takeover,
    output logic        slave_on,
    output logic        ttl_sel
);
    localparam logic [W-1:0] MASK_HALF = W'(1) << LSB;
    localparam logic [W-1:0] MASK_FULL = W'(7) << LSB;

    port_state_t state_nx;

    always_comb begin
        if (pwm_mode[1])
            state_nx = ST_FULL;
        else if (pwm_mode == PWM_HALF)
            state_nx = ST_HALF;
        else if (slave_req)
            state_nx = ST_SLAVE;
        else
            state_nx = ST_GPIO;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_GPIO;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_GPIO:  begin takeover = '0;        slave_on = 1'b0; end
            ST_SLAVE: begin takeover = '0;        slave_on = 1'b1; end
            ST_HALF:  begin takeover = MASK_HALF; slave_on = 1'b0; end
            ST_FULL:  begin takeover = MASK_FULL; slave_on = 1'b0; end
            default:  begin takeover = '0;        slave_on = 1'b0; end
        endcase
        ttl_sel = slave_on;
    end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int W = 8
) (
    input  logic [W-1:0] takeover,
    input  logic [W-1:0] pwm_lvl,
    input  logic         slave_on,
    input  logic         slave_drive,
    input  logic [W-1:0] slave_dout,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] latch_q,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            always_comb begin
                if (takeover[i]) begin
                    pad_oe[i]  = 1'b1;
                    pad_out[i] = pwm_lvl[i];
                end else if (slave_on) begin
                    pad_oe[i]  = slave_drive;
                    pad_out[i] = slave_dout[i];
                end else begin
                    pad_oe[i]  = ~dir_q[i];
                    pad_out[i] = latch_q[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W           = PORT_W,
    parameter int SYNC_STAGES = 2,
    parameter int PWM_POS     = PWM_LSB
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_we,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    input  logic [1:0]   pwm_mode,
    input  logic         pwm_b,
    input  logic         pwm_c,
    input  logic         pwm_d,
    input  logic         slave_req,
    input  logic         slave_drive,
    input  logic [W-1:0] slave_dout,
    output logic         slave_active,
    output logic         ttl_sel
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] takeover;
    logic [W-1:0] pwm_lvl;
    port_state_t  state;

    always_comb begin
        pwm_lvl = '0;
        pwm_lvl[PWM_POS +: 3] = {pwm_d, pwm_c, pwm_b};
    end

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .pin_sync(pin_sync), .latch_q(latch_q),
        .dir_q(dir_q), .rdata(bus_rdata)
    );

    gpio_mode_fsm #(.W(W), .LSB(PWM_POS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwm_mode(pwm_mode), .slave_req(slave_req),
        .state(state), .takeover(takeover), .slave_on(slave_active),
        .ttl_sel(ttl_sel)
    );

    gpio_pin_mux #(.W(W)) u_mux (
        .takeover(takeover), .pwm_lvl(pwm_lvl), .slave_on(slave_active),
        .slave_drive(slave_drive), .slave_dout(slave_dout), .dir_q(dir_q),
        .latch_q(latch_q), .pad_out(pad_out), .pad_oe(pad_oe)
    );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int W       = 8,
    parameter int PWM_POS = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   bus_addr,
    input logic         bus_we,
    input logic [W-1:0] bus_wdata,
    input logic [1:0]   pwm_mode,
    input logic         slave_active,
    input logic [W-1:0] pad_oe,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] latch_q,
    input port_state_t  state
);
    logic latch_wr;
    assign latch_wr = bus_we && (bus_addr == ADDR_PIN || bus_addr == ADDR_LAT);

    AST_GPIO_DIR: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_GPIO) |-> (pad_oe == ~dir_q)); // R2
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !latch_wr |=> $stable(latch_q)); // R3
    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n) latch_wr |=> (latch_q == $past(bus_wdata))); // R4
    AST_TAKEOVER_OE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_FULL) |-> (pad_oe[PWM_POS +: 3] == 3'b111)); // R6
    AST_SLAVE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (pwm_mode != PWM_OFF) |=> !slave_active); // R8
endmodule

bind gpio_port gpio_port_chk #(.W(W), .PWM_POS(PWM_POS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pwm_mode(pwm_mode), .slave_active(slave_active),
    .pad_oe(pad_oe), .dir_q(dir_q), .latch_q(latch_q), .state(state)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [1:0] pwm_mode = 2'b00;
    logic       pwm_b = 1'b0, pwm_c = 1'b0, pwm_d = 1'b0;
    logic       slave_req = 1'b0, slave_drive = 1'b0;
    logic [7:0] slave_dout = 8'h00;
    logic       slave_active, ttl_sel;
    logic [7:0] ext = 8'h00;

    int checks = 0;
    int fails  = 0;
    logic [7:0] m_dir = 8'hFF;
    logic [7:0] m_lat = 8'h00;

    always #4 clk = ~clk;

    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pwm_mode(pwm_mode),
        .pwm_b(pwm_b), .pwm_c(pwm_c), .pwm_d(pwm_d), .slave_req(slave_req),
        .slave_drive(slave_drive), .slave_dout(slave_dout),
        .slave_active(slave_active), .ttl_sel(ttl_sel)
    );

    function automatic logic [7:0] f_take(input logic [1:0] m);
        if (m[1])         return 8'hE0;
        else if (m == 2'b01) return 8'h20;
        return 8'h00;
    endfunction

    function automatic logic f_slave(input logic [1:0] m, input logic req);
        return (m == 2'b00) && req;
    endfunction

    function automatic logic [7:0] f_oe(input logic [1:0] m, input logic req,
                                        input logic drv, input logic [7:0] dir);
        logic [7:0] base;
        base = f_slave(m, req) ? {8{drv}} : ~dir;
        return f_take(m) | (~f_take(m) & base);
    endfunction

    function automatic logic [7:0] f_out(input logic [1:0] m, input logic req,
                                         input logic [7:0] sd, input logic [7:0] lat,
                                         input logic [7:0] pw);
        logic [7:0] base;
        base = f_slave(m, req) ? sd : lat;
        return (f_take(m) & pw) | (~f_take(m) & base);
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
        if (a == 2'd0 || a == 2'd1) m_lat = d;
        if (a == 2'd2) m_dir = d;
    endtask

    function automatic logic [7:0] rd_now(input logic [1:0] a);
        return 8'h00;
    endfunction

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        logic [7:0] pw;
        logic [7:0] eo;
        pw = {pwm_d, pwm_c, pwm_b, 5'b0};
        eo = f_oe(pwm_mode, slave_req, slave_drive, m_dir);
        check({tag, " R6 R7 R2 oe"}, pad_oe, eo);
        check({tag, " R6 R7 R2 out"}, pad_out & eo,
              f_out(pwm_mode, slave_req, slave_dout, m_lat, pw) & eo);
        check({tag, " R7 R8 slave_active"}, {7'b0, slave_active}, {7'b0, f_slave(pwm_mode, slave_req)});
        check({tag, " R7 R8 ttl_sel"}, {7'b0, ttl_sel}, {7'b0, f_slave(pwm_mode, slave_req)});
        rd(2'd1, v); check({tag, " R3 latch read"}, v, m_lat);
        rd(2'd2, v); check({tag, " R9 dir read"}, v, m_dir);
        rd(2'd3, v); check({tag, " R9 addr3 read"}, v, 8'h00);
        rd(2'd0, v);
        check({tag, " R5 pin read"}, v,
              (eo & f_out(pwm_mode, slave_req, slave_dout, m_lat, pw)) | (~eo & ext));
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED_0042));
        repeat (3) tick();
        // R1 reset state
        check("R1 oe at reset", pad_oe, 8'h00);
        rd(2'd2, v); check("R1 dir at reset", v, 8'hFF);
        rd(2'd1, v); check("R1 latch at reset", v, 8'h00);
        check("R1 slave_active at reset", {7'b0, slave_active}, 8'h00);
        rst_n = 1'b1;
        tick();
        check_all("R1 after release");

        // R2 direction example
        wr(2'd2, 8'hCF);
        check("R2 dir 0xCF oe", pad_oe, 8'h30);

        // R4 latency and both write addresses; R3 latch vs pin
        ext = 8'hA5;
        wr(2'd2, 8'hFF);
        bus_addr = 2'd1; bus_wdata = 8'h3C; bus_we = 1'b1;
        #1; check("R4 latch before edge", bus_rdata, 8'h00);
        tick(); bus_we = 1'b0; m_lat = 8'h3C;
        rd(2'd1, v); check("R4 latch after one edge", v, 8'h3C);
        repeat (3) tick();
        rd(2'd1, v); check("R3 latch not pin level", v, 8'h3C);
        rd(2'd0, v); check("R3 pin read is pad", v, 8'hA5);
        wr(2'd0, 8'h00);
        rd(2'd1, v); check("R4 clear via pin address", v, 8'h00);
        wr(2'd1, 8'h81);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R4 clear via latch address", v, 8'h00);

        // R9 address 3 write ignored
        wr(2'd1, 8'h5A);
        bus_addr = 2'd3; bus_wdata = 8'hFF; bus_we = 1'b1; tick(); bus_we = 1'b0;
        rd(2'd1, v); check("R9 addr3 write latch unchanged", v, 8'h5A);
        rd(2'd2, v); check("R9 addr3 write dir unchanged", v, 8'hFF);

        // R5 two-stage sync latency
        ext = 8'h00; repeat (3) tick();
        ext = 8'h6E; bus_addr = 2'd0;
        tick(); check("R5 pin after one edge", bus_rdata, 8'h00);
        tick(); check("R5 pin after two edges", bus_rdata, 8'h6E);

        // R8 slave request under PWM, then release
        slave_req = 1'b1; slave_drive = 1'b1; slave_dout = 8'hC3;
        pwm_mode = 2'b10; pwm_b = 1'b1; pwm_c = 1'b0; pwm_d = 1'b1;
        tick(); check("R8 slave blocked by full bridge", {7'b0, slave_active}, 8'h00);
        repeat (3) tick(); check_all("R8 full bridge");
        pwm_mode = 2'b01; repeat (4) tick(); check_all("R8 half bridge");
        pwm_mode = 2'b00; tick();
        check("R7 slave after one edge", {7'b0, slave_active}, 8'h01);
        repeat (3) tick(); check_all("R7 slave");

        // random mix
        for (int i = 0; i < 400; i++) begin
            wr(2'd2, 8'($urandom));
            wr(2'($urandom_range(0, 1)), 8'($urandom));
            ext = 8'($urandom);
            pwm_mode = 2'($urandom);
            slave_req = 1'($urandom);
            slave_drive = 1'($urandom);
            slave_dout = 8'($urandom);
            pwm_b = 1'($urandom); pwm_c = 1'($urandom); pwm_d = 1'($urandom);
            repeat (4) tick();
            check_all("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule